// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a serial EEPROM with a three-wire interface: chip select, serial clock and a data line in each direction. The host presents a word address with a one-cycle `start` pulse while `busy` is low. The block then runs one whole read transaction on the serial pins. It raises chip select and sends a start bit, a two-bit read opcode and the address. It clocks in sixteen data bits, drops chip select, and reports the word with a one-cycle `done` pulse.

The request side has no back-pressure other than `busy`. A `start` seen while `busy` is high is dropped, not queued. The result side is a plain valid pulse with no ready, and `rdata` holds the word until the next transaction completes. `ADDR_W` picks the address length for the device in use: 8 for the smaller part and 10 for the larger part in 16-bit word mode. `HALF_DIV` sets how many system clock cycles each serial clock level lasts, which keeps the serial clock inside the device's timing limits.

Top module: `mw_word_reader`

## Requirements
- R1: After reset, and whenever no transaction is running, `ee_cs`, `ee_sk`, `ee_do`, `busy` and `done` are all low, and `rdata` is zero after reset.
- R2: A `start` sampled high at a rising clock edge while `busy` is low is accepted. From the next cycle, `ee_cs` is high for one select half-period with `ee_sk` and `ee_do` low.
- R3: The bits sent after the select half-period are the start bit 1, then the read opcode 1 then 0, then the address most significant bit first. Each bit takes one low half-period with `ee_do` at the bit value, then one high half-period. `ee_do` changes only while `ee_sk` is low.
- R4: Every serial clock half-period lasts exactly `HALF_DIV` system clock cycles, and each high level of `ee_sk` lasts one half-period.
- R5: After the last address bit comes one low half-period with `ee_do` low. Then sixteen input bits follow, each a high half-period then a low half-period. `ee_di` is sampled in the last system cycle of each low half-period, and the bits are assembled most significant bit first.
- R6: When the last input bit is taken, `ee_cs` and `ee_sk` drop and `done` is high for exactly one cycle. In that cycle `rdata` carries the sixteen bits, and `rdata` then holds until the next completion.
- R7: `busy` is high from the cycle after acceptance until the last half-period ends, and it is low in the `done` cycle. A `start` while `busy` is high has no effect. A `start` during the `done` cycle is accepted.
- R8: One transaction lasts (2*(3+`ADDR_W`) + 2 + 32) * `HALF_DIV` cycles from the cycle after acceptance to the `done` cycle.
- R9: Asserting `rst_n` low during a transaction returns every output to the R1 state, and the next `start` begins a fresh transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted while busy is low |
| start_addr | input | ADDR_W | Word address captured with an accepted start |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word read by the last completed transaction |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial data towards the EEPROM |
| ee_di | input | 1 | Serial data from the EEPROM |

## Verification
The bench runs the design with a 10-bit address and a three-cycle half-period. It reads all-zero, all-one and alternating addresses so that `ee_do` both toggles on every bit and holds across runs of equal bits. If the design shifted the address in the wrong order, or changed `ee_do` while the clock is high, the per-cycle comparison would catch it, and so would the word returned by the EEPROM model. A second `start` in mid-transaction would corrupt the word or stretch the transaction if it were not ignored. A `start` held through the `done` cycle shows whether the design loses the back-to-back request at its only acceptance point. A reset in mid-read shows whether stale shift state survives into the next read.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

  // Kind of the half-period the sequencer is in
  typedef enum logic [1:0] {
    PK_SEL  = 2'd0,   // chip select up, clock and data idle
    PK_TX   = 2'd1,   // command / address bit going out
    PK_TURN = 2'd2,   // low gap between address and data
    PK_RX   = 2'd3    // data bit coming in
  } phase_kind_e;

  // Registered serial pin set
  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } pins_t;

  localparam logic [2:0] LEAD_BITS = 3'b110;  // start bit then read opcode
  localparam int         LEAD_W    = 3;

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  generate
    if (HALF_DIV <= 1) begin : g_every
      assign half_end = run;
    end else begin : g_count
      localparam int DIV_W = $clog2(HALF_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (!run)             div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end

      assign half_end = run && (div_q == DIV_LAST);
    end
  endgenerate
endmodule

// File: rtl/mw_cmd_shifter.sv
module mw_cmd_shifter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] frame,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr_q <= '0;
    else if (load) sr_q <= frame;
    else if (step) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/mw_rx_shifter.sv
module mw_rx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic [W-1:0] sr_q;

  assign nxt = {sr_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (sample) sr_q <= nxt;
  end
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mw_rd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_do,
  input  logic              ee_di
);
  localparam int N_TX   = LEAD_W + ADDR_W;
  localparam int TURN_P = 1 + 2 * N_TX;
  localparam int RX0_P  = TURN_P + 1;
  localparam int LAST_P = RX0_P + 2 * DATA_W - 1;
  localparam int PH_W   = $clog2(LAST_P + 1);
  localparam logic [PH_W-1:0] TURN_V = PH_W'(TURN_P);
  localparam logic [PH_W-1:0] RX0_V  = PH_W'(RX0_P);
  localparam logic [PH_W-1:0] LAST_V = PH_W'(LAST_P);

  logic              busy_q, done_q;
  logic [PH_W-1:0]   ph_q, ph_nx;
  logic [DATA_W-1:0] rdata_q, rx_word;
  pins_t             pins_q, pins_nx;
  logic              half_end, accept, cmd_bit, cmd_step, rx_sample;
  phase_kind_e       kind_cur, kind_nx;

  function automatic phase_kind_e classify(input logic [PH_W-1:0] p);
    if (p == '0)          return PK_SEL;
    else if (p < TURN_V)  return PK_TX;
    else if (p == TURN_V) return PK_TURN;
    else                  return PK_RX;
  endfunction

  // High half of the serial clock: second half of a TX bit, first half of an RX bit
  function automatic logic high_half(input logic [PH_W-1:0] p);
    logic [PH_W-1:0] off;
    case (classify(p))
      PK_TX:   begin off = p - PH_W'(1); return off[0];  end
      PK_RX:   begin off = p - RX0_V;    return ~off[0]; end
      default: return 1'b0;
    endcase
  endfunction

  assign accept   = start && !busy_q;
  assign ph_nx    = ph_q + 1'b1;
  assign kind_cur = classify(ph_q);
  assign kind_nx  = classify(ph_nx);

  mw_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .half_end (half_end)
  );

  // Advance the outgoing frame as each bit is placed on the data line
  assign cmd_step = half_end && (kind_nx == PK_TX) && !high_half(ph_nx);

  mw_cmd_shifter #(.W(N_TX)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (cmd_step),
    .frame ({LEAD_BITS, start_addr}),
    .msb   (cmd_bit)
  );

  // Take the input bit at the end of each low half of a receive bit
  assign rx_sample = half_end && (kind_cur == PK_RX) && !high_half(ph_q);

  mw_rx_shifter #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rx_sample),
    .din    (ee_di),
    .nxt    (rx_word)
  );

  // Pin levels for the following half-period; data moves only in low halves
  always_comb begin
    pins_nx.cs   = 1'b1;
    pins_nx.sk   = high_half(ph_nx);
    pins_nx.dout = 1'b0;
    if (kind_nx == PK_TX)
      pins_nx.dout = pins_nx.sk ? pins_q.dout : cmd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= '0;
      pins_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        pins_q <= '{cs: 1'b1, sk: 1'b0, dout: 1'b0};
      end else if (half_end) begin
        if (ph_q == LAST_V) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          pins_q  <= '0;
          rdata_q <= rx_word;
        end else begin
          ph_q   <= ph_nx;
          pins_q <= pins_nx;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;
  assign ee_cs = pins_q.cs;
  assign ee_sk = pins_q.sk;
  assign ee_do = pins_q.dout;

endmodule

// File: rtl/mw_reader_chk.sv
module mw_reader_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do
);
  logic        sk_q;
  logic [15:0] run_q;

  // Length of the current serial clock level in system cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q  <= 1'b0;
      run_q <= 16'd1;
    end else begin
      sk_q  <= ee_sk;
      run_q <= (ee_sk != sk_q) ? 16'd1 : run_q + 16'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_do));

  // R2
  select_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (busy && !ee_sk && !ee_do));

  // R3
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_do));

  // R4
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_q && !ee_sk) |-> (run_q == 16'(HALF_DIV)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !ee_cs));

endmodule

bind mw_word_reader mw_reader_chk #(.HALF_DIV(HALF_DIV)) u_reader_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .ee_cs (ee_cs),
  .ee_sk (ee_sk),
  .ee_do (ee_do)
);

// File: tb/tb_mw_word_reader.sv
module tb_mw_word_reader;
  localparam int AW     = 10;
  localparam int HD     = 3;
  localparam int DW     = 16;
  localparam int NT     = 3 + AW;
  localparam int HALVES = 2 + 2 * NT + 2 * DW;
  localparam int DONE_C = HALVES * HD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          busy, done, ee_cs, ee_sk, ee_do;
  logic [DW-1:0] rdata;
  logic          ee_di = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mw_word_reader #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [31:0] v;
    v = 32'(a) * 32'd40503 + 32'h3C5A;
    return v[DW-1:0] ^ (DW'(a) << 5);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // EEPROM model: takes bits on rising serial clock, returns data after address
  int            ee_bits = 0;
  logic [AW-1:0] ee_addr = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      ee_bits = 0;
      ee_di   = 1'b0;
    end else begin
      logic [DW-1:0] w;
      ee_bits++;
      if (ee_bits > 3 && ee_bits <= NT) ee_addr = {ee_addr[AW-2:0], ee_do};
      w = word_at(ee_addr);
      if (ee_bits == NT) ee_di = 1'b0;
      else if (ee_bits > NT && ee_bits <= NT + DW) ee_di = w[DW - (ee_bits - NT)];
    end
  end

  // Cycle reference model
  bit            m_act = 1'b0;
  int            m_c = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act   = 1'b0;
      m_c     = 0;
      m_rdata = '0;
    end else begin
      bit was_busy;
      was_busy = m_act && (m_c < DONE_C);
      if (m_act && m_c == DONE_C - 1) m_rdata = word_at(m_addr);
      if (!was_busy && start) begin
        m_act  = 1'b1;
        m_c    = 0;
        m_addr = start_addr;
      end else if (m_act) begin
        if (m_c == DONE_C) m_act = 1'b0;
        else m_c++;
      end
    end
  end

  function automatic int exp_sk(input int p);
    if (p == 0) return 0;
    if (p <= 2 * NT) return ((p - 1) % 2 == 1) ? 1 : 0;
    if (p == 2 * NT + 1) return 0;
    return ((p - 2 * NT - 2) % 2 == 0) ? 1 : 0;
  endfunction

  function automatic int exp_do(input int p, input logic [AW-1:0] a);
    int k;
    if (p < 1 || p > 2 * NT) return 0;
    k = (p - 1) / 2;
    if (k < 2) return 1;
    if (k == 2) return 0;
    return int'(a[AW - 1 - (k - 3)]);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit eb, ed;
      int p;
      eb = m_act && (m_c < DONE_C);
      ed = m_act && (m_c == DONE_C);
      p  = m_c / HD;
      check("R7", "busy", int'(busy), int'(eb));
      check("R6", "done", int'(done), int'(ed));
      check("R2", "ee_cs", int'(ee_cs), int'(eb));
      check("R4", "ee_sk", int'(ee_sk), eb ? exp_sk(p) : 0);
      check("R3", "ee_do", int'(ee_do), eb ? exp_do(p, m_addr) : 0);
      check("R6", "rdata", int'(rdata), int'(m_rdata));
    end
  end

  task automatic read_word(input logic [AW-1:0] a);
    int n;
    while (busy) @(negedge clk);
    start = 1'b1;
    start_addr = a;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
    end
    check("R8", "cycles", n, DONE_C);
    check("R5", "word", int'(rdata), int'(word_at(a)));
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "idle pins", int'({ee_cs, ee_sk, ee_do, busy, done}), 0);
    check("R1", "rdata", int'(rdata), 0);

    read_word('0);
    read_word('1);
    read_word(10'h155);
    read_word(10'h2AA);
    read_word(10'h1E3);

    // R7: a start while busy is ignored
    start = 1'b1;
    start_addr = 10'h0F0;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    start = 1'b1;
    start_addr = 10'h00F;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R7", "ignored start word", int'(rdata), int'(word_at(10'h0F0)));
    @(negedge clk);
    check("R7", "no second run", int'(busy), 0);

    // R7: start held through the done cycle is accepted back to back
    start = 1'b1;
    start_addr = 10'h301;
    while (!done) @(negedge clk);
    start_addr = 10'h0C4;
    @(negedge clk);
    start = 1'b0;
    check("R7", "back-to-back accept", int'(busy), 1);
    while (!done) @(negedge clk);
    check("R7", "second word", int'(rdata), int'(word_at(10'h0C4)));
    @(negedge clk);

    // R9: reset in mid-transaction
    start = 1'b1;
    start_addr = 10'h3C3;
    @(negedge clk);
    start = 1'b0;
    repeat (70) @(negedge clk);
    @(posedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R9", "pins in reset", int'({ee_cs, ee_sk, ee_do, busy, done}), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9", "rdata cleared", int'(rdata), 0);
    read_word(10'h3C3);
    read_word(10'h001);

    finish_run();
  end
endmodule